// File: doc/BRIEF.md
# Programmable LCD Display Timing Generator

This block produces the raster timing for a TFT or STN style LCD panel. It keeps a pixel counter and a line counter that advance only on cycles where the pixel clock enable is high. From those counts and a small set of configuration registers it decodes a horizontal sync pulse, a vertical sync pulse, a data-enable flag that marks the displayed area, and the coordinates of the current displayed pixel.

The first displayed pixel and the first displayed line are set by their own offset registers. Horizontal blanking starts where the active width ends. The horizontal sync pulse is placed relative to that blanking start, using a programmable delay and a programmable width. Software writes the configuration through a simple write-only port into a staging copy. The live timing picks up the staging copy only on the enabled cycle that ends a frame, so a frame never mixes old and new settings.

Top module: `lcd_timing_gen`

## Requirements
- R1: After synchronous active-low reset every configuration field and both counters are 0, so de_o is 0, both coordinates are 0, and hsync_o and vsync_o sit at their inactive level of 1.
- R2: The pixel counter advances only on cycles with pclk_en high. It wraps to 0 after the value h_total-1, or on every enabled cycle when h_total is 0 or 1. On each wrap the line counter advances, and the line counter wraps to 0 after v_total-1.
- R3: de_o is 1 exactly when pix_off <= pixel count < pix_off + h_active and line_off <= line count < line_off + v_active.
- R4: While de_o is 1, pix_x_o equals pixel count minus pix_off and line_y_o equals line count minus the effective line_off. Both outputs are 0 while de_o is 0.
- R5: The horizontal sync is active for pixel counts in [b, b + w), where b = pix_off + h_active + hs_delay and w is hs_width, with a hs_width of 0 treated as 1.
- R6: When control bit 0 (hsync enable) is 0, hsync_o stays at its inactive level for the whole frame.
- R7: Control bit 1 selects the hsync polarity and control bit 2 selects the vsync polarity. A value of 1 means active-high and 0 means active-low; the inactive level is the inverse of the selected active level.
- R8: The vertical sync is active for line counts in [vs_line, vs_line + vs_lines).
- R9: When control bit 3 (TFT mode) is 1, a line_off below 2 is used as 2. In STN mode (bit 3 = 0) a line_off of 0 is used as written.
- R10: Writes update only the staging copy. The live timing loads the staging copy on the enabled cycle where both counters wrap. A write made in that same cycle waits for the next frame.
- R11: Register map, written when wr_en is 1:
  - Address 0: control, bits 3:0.
  - Address 1: line_off in bits 15:8 and pix_off in bits 7:0.
  - Address 2: hs_width in bits 15:8 and hs_delay in bits 7:0.
  - Addresses 3 to 8, bits 9:0: h_total, h_active, v_total, v_active, vs_line and vs_lines in that order.
  - Other addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pclk_en | input | 1 | Pixel clock enable; counters step when high |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration register address |
| wr_data | input | 16 | Configuration write data |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 1 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 2 |
| de_o | output | 1 | Data enable, high inside the displayed area |
| pix_x_o | output | 10 | Displayed pixel column, 0 outside the area |
| line_y_o | output | 10 | Displayed line row, 0 outside the area |

## Verification
A wrong counter value shows at the ports as shifted data-enable edges and shifted coordinates within the same line. A missed or extra line step shifts the vertical window, which shows within one line period. A live configuration that loads at the wrong moment moves a window edge in the middle of a frame, visible as soon as the counter crosses that edge. The reference model steps through every enabled cycle and compares all five outputs on every clock, so such a fault is caught on the first cycle where its output differs.

// File: rtl/lcd_tg_pkg.sv
// Package: shared widths, register addresses and the configuration record
// for the LCD timing generator. Assumes 10-bit counts and 8-bit offsets.
package lcd_tg_pkg;
    parameter int CNT_W  = 10;
    parameter int OFS_W  = 8;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 4;
    parameter int CTRL_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL    = 4'd0,
        A_OFFSETS = 4'd1,
        A_HSYNC   = 4'd2,
        A_HTOTAL  = 4'd3,
        A_HACTIVE = 4'd4,
        A_VTOTAL  = 4'd5,
        A_VACTIVE = 4'd6,
        A_VSLINE  = 4'd7,
        A_VSLINES = 4'd8
    } tg_addr_e;

    typedef struct packed {
        logic             tft;
        logic             vs_pol;
        logic             hs_pol;
        logic             hs_oe;
        logic [OFS_W-1:0] line_off;
        logic [OFS_W-1:0] pix_off;
        logic [OFS_W-1:0] hs_width;
        logic [OFS_W-1:0] hs_delay;
        logic [CNT_W-1:0] h_total;
        logic [CNT_W-1:0] h_active;
        logic [CNT_W-1:0] v_total;
        logic [CNT_W-1:0] v_active;
        logic [CNT_W-1:0] vs_line;
        logic [CNT_W-1:0] vs_lines;
    } tg_cfg_t;
endpackage

// File: rtl/lcd_tg_cfg.sv
// Configuration store: a staging copy written by the register port and a
// live copy that the timing uses. Assumes frame_load pulses for one cycle
// at the enabled frame wrap; the live copy changes at no other time.
module lcd_tg_cfg
    import lcd_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_load,
    output tg_cfg_t           live_cfg
);
    tg_cfg_t stage_q;
    tg_cfg_t live_q;

    // Staging register: decode the write address and update one field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    stage_q.hs_oe  <= wr_data[0];
                    stage_q.hs_pol <= wr_data[1];
                    stage_q.vs_pol <= wr_data[2];
                    stage_q.tft    <= wr_data[3];
                end
                A_OFFSETS: begin
                    stage_q.pix_off  <= wr_data[OFS_W-1:0];
                    stage_q.line_off <= wr_data[2*OFS_W-1:OFS_W];
                end
                A_HSYNC: begin
                    stage_q.hs_delay <= wr_data[OFS_W-1:0];
                    stage_q.hs_width <= wr_data[2*OFS_W-1:OFS_W];
                end
                A_HTOTAL:  stage_q.h_total  <= wr_data[CNT_W-1:0];
                A_HACTIVE: stage_q.h_active <= wr_data[CNT_W-1:0];
                A_VTOTAL:  stage_q.v_total  <= wr_data[CNT_W-1:0];
                A_VACTIVE: stage_q.v_active <= wr_data[CNT_W-1:0];
                A_VSLINE:  stage_q.vs_line  <= wr_data[CNT_W-1:0];
                A_VSLINES: stage_q.vs_lines <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Live register: copy the staging record only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (frame_load) begin
            live_q <= stage_q;
        end
    end

    assign live_cfg = live_q;

    // The live timing must not move except at a frame boundary.
    assert_live_frame_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> $stable(live_q));
endmodule

// File: rtl/lcd_tg_counters.sv
// Pixel and line counters. Both step only when pclk_en is high. The pixel
// counter wraps after h_total-1 and the line counter after v_total-1. Totals
// of 0 or 1 hold a counter at 0. Assumes the totals change only while
// both counters are 0, which is when frame_load fires.
module lcd_tg_counters
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pclk_en,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] v_total,
    output logic [CNT_W-1:0] pix_cnt,
    output logic [CNT_W-1:0] line_cnt,
    output logic             frame_load
);
    localparam int XW = CNT_W + 1;

    logic [CNT_W-1:0] pix_q, line_q;
    logic             pix_last, line_last;

    // End-of-line and end-of-frame detection; next count reaching the total.
    always_comb begin
        pix_last  = (XW'(pix_q) + XW'(1))  >= XW'(h_total);
        line_last = (XW'(line_q) + XW'(1)) >= XW'(v_total);
    end

    assign frame_load = pclk_en && pix_last && line_last;

    // Counter update on enabled cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q  <= '0;
            line_q <= '0;
        end else if (pclk_en) begin
            if (pix_last) begin
                pix_q  <= '0;
                line_q <= line_last ? '0 : line_q + 1'b1;
            end else begin
                pix_q <= pix_q + 1'b1;
            end
        end
    end

    assign pix_cnt  = pix_q;
    assign line_cnt = line_q;

    // Counters hold when the pixel clock enable is low.
    assert_hold_without_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pclk_en |=> ($stable(pix_q) && $stable(line_q)));
    // The line counter only moves while the pixel counter returns to 0.
    assert_line_steps_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_en && !pix_last) |=> $stable(line_q));
endmodule

// File: rtl/lcd_tg_decode.sv
// Output decode: data-enable window, active coordinates, horizontal and
// vertical sync with polarity and enable. Purely combinational from the
// counters and the live configuration, so outputs follow the counters
// with no extra delay.
module lcd_tg_decode
    import lcd_tg_pkg::*;
#(
    parameter int TFT_MIN_LINE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tg_cfg_t          cfg,
    input  logic [CNT_W-1:0] pix_cnt,
    input  logic [CNT_W-1:0] line_cnt,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [CNT_W-1:0] pix_x_o,
    output logic [CNT_W-1:0] line_y_o
);
    localparam int EW = CNT_W + 3;

    logic [EW-1:0] px, ln, pix_off, line_off, hb_start, hs_beg, hs_len;
    logic          in_h, in_v, hs_act, vs_act, de;

    // Window arithmetic in a widened domain so sums never wrap.
    always_comb begin
        px       = EW'(pix_cnt);
        ln       = EW'(line_cnt);
        pix_off  = EW'(cfg.pix_off);
        line_off = (cfg.tft && (EW'(cfg.line_off) < EW'(TFT_MIN_LINE)))
                   ? EW'(TFT_MIN_LINE) : EW'(cfg.line_off);
        hb_start = pix_off + EW'(cfg.h_active);
        hs_beg   = hb_start + EW'(cfg.hs_delay);
        hs_len   = (cfg.hs_width == '0) ? EW'(1) : EW'(cfg.hs_width);
        in_h     = (px >= pix_off) && (px < hb_start);
        in_v     = (ln >= line_off) && (ln < line_off + EW'(cfg.v_active));
        de       = in_h && in_v;
        hs_act   = cfg.hs_oe && (px >= hs_beg) && (px < hs_beg + hs_len);
        vs_act   = (ln >= EW'(cfg.vs_line)) && (ln < EW'(cfg.vs_line) + EW'(cfg.vs_lines));
    end

    // Drive the port levels: polarity select and coordinates inside the area.
    always_comb begin
        de_o     = de;
        hsync_o  = hs_act ? cfg.hs_pol : ~cfg.hs_pol;
        vsync_o  = vs_act ? cfg.vs_pol : ~cfg.vs_pol;
        pix_x_o  = de ? CNT_W'(px - pix_off)  : '0;
        line_y_o = de ? CNT_W'(ln - line_off) : '0;
    end

    // With the hsync enable clear the pin sits at its inactive level.
    assert_hsync_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.hs_oe |-> (hsync_o == ~cfg.hs_pol));
    // Data enable never precedes the first active pixel.
    assert_de_after_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (pix_cnt >= CNT_W'(cfg.pix_off)));
    // In TFT mode no displayed line precedes line 2.
    assert_tft_line_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (de_o && cfg.tft) |-> (line_cnt >= CNT_W'(TFT_MIN_LINE)));
    // Coordinates stay 0 outside the displayed area.
    assert_coords_zero_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !de_o |-> (pix_x_o == '0 && line_y_o == '0));
endmodule

// File: rtl/lcd_timing_gen.sv
// Top of the LCD timing generator: configuration store, counters and
// output decode. Assumes one system clock with a pixel clock enable and a
// synchronous active-low reset.
module lcd_timing_gen
    import lcd_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [CNT_W-1:0]  pix_x_o,
    output logic [CNT_W-1:0]  line_y_o
);
    tg_cfg_t          live_cfg;
    logic [CNT_W-1:0] pix_cnt, line_cnt;
    logic             frame_load;

    lcd_tg_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_load (frame_load),
        .live_cfg   (live_cfg)
    );

    lcd_tg_counters u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pclk_en    (pclk_en),
        .h_total    (live_cfg.h_total),
        .v_total    (live_cfg.v_total),
        .pix_cnt    (pix_cnt),
        .line_cnt   (line_cnt),
        .frame_load (frame_load)
    );

    lcd_tg_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (live_cfg),
        .pix_cnt  (pix_cnt),
        .line_cnt (line_cnt),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .de_o     (de_o),
        .pix_x_o  (pix_x_o),
        .line_y_o (line_y_o)
    );
endmodule

// File: tb/lcd_timing_gen_tb_top.sv
// Bench: behavioural reference model stepped on every clock, compared with
// the ports on every falling edge.
module lcd_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pclk_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        hsync_o, vsync_o, de_o;
    logic [9:0]  pix_x_o, line_y_o;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int en_mode = 0;
    bit armed = 0;
    string phase = "R1_reset";

    int st[9];
    int lv[9];
    int px = 0, ln = 0;

    always #5 clk = ~clk;

    lcd_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .pix_x_o(pix_x_o), .line_y_o(line_y_o)
    );

    // Reference model: counters and two config copies (R2, R10, R11).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 9; i++) begin st[i] = 0; lv[i] = 0; end
            px = 0; ln = 0;
            armed = 1;
        end else begin
            if (pclk_en) begin
                if (px + 1 >= lv[3]) begin
                    px = 0;
                    if (ln + 1 >= lv[5]) begin
                        ln = 0;
                        for (int i = 0; i < 9; i++) lv[i] = st[i];
                    end else ln = ln + 1;
                end else px = px + 1;
            end
            if (wr_en) begin
                if (wr_addr == 0) st[0] = wr_data & 'hF;
                else if (wr_addr <= 2) st[wr_addr] = wr_data;
                else if (wr_addr <= 8) st[wr_addr] = wr_data & 'h3FF;
            end
        end
    end

    // Pixel clock enable pattern: always, every other, or two of three.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        case (en_mode)
            0: pclk_en <= 1'b1;
            1: pclk_en <= cyc[0];
            default: pclk_en <= (cyc % 3) != 0;
        endcase
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
        end
    endtask

    // Compare every output with the model each cycle.
    always @(negedge clk) begin
        if (armed) begin
            int ctrl, poff, loff, hb, hsb, hsl, ein, hact, vact, de, ex, ey;
            ctrl = lv[0];
            poff = lv[1] & 255;
            loff = lv[1] >> 8;
            if ((ctrl & 8) != 0 && loff < 2) loff = 2;       // R9
            hb   = poff + lv[4];
            hsb  = hb + (lv[2] & 255);
            hsl  = (lv[2] >> 8) == 0 ? 1 : (lv[2] >> 8);
            de   = (px >= poff && px < hb && ln >= loff && ln < loff + lv[6]) ? 1 : 0;
            hact = ((ctrl & 1) != 0 && px >= hsb && px < hsb + hsl) ? 1 : 0;   // R5 R6
            vact = (ln >= lv[7] && ln < lv[7] + lv[8]) ? 1 : 0;                 // R8
            ex   = de ? px - poff : 0;
            ey   = de ? ln - loff : 0;
            chk("R3 de", int'(de_o), de);
            chk("R4 x", int'(pix_x_o), ex);
            chk("R4 y", int'(line_y_o), ey);
            chk("R5 R7 hsync", int'(hsync_o), hact ? ((ctrl >> 1) & 1) : 1 - ((ctrl >> 1) & 1));
            chk("R8 R7 vsync", int'(vsync_o), vact ? ((ctrl >> 2) & 1) : 1 - ((ctrl >> 2) & 1));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en <= 1'b1; wr_addr <= 4'(a); wr_data <= 16'(d);
        @(negedge clk);
        wr_en <= 1'b0;
    endtask

    task automatic setup(int ctrl, int lo, int po, int hw, int hd,
                         int ht, int ha, int vt, int va, int vl, int vn);
        wr(0, ctrl); wr(1, (lo << 8) | po); wr(2, (hw << 8) | hd);
        wr(3, ht); wr(4, ha); wr(5, vt); wr(6, va); wr(7, vl); wr(8, vn);
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, outputs inactive
        repeat (3) @(negedge clk);
        chk("R1 de", int'(de_o), 0);
        chk("R1 hsync", int'(hsync_o), 1);
        chk("R1 vsync", int'(vsync_o), 1);
        rst_n <= 1'b1;
        run(5);
        // R2 R3 R4 R5 R8 R11: STN, hsync enabled active-high, full-rate enable
        phase = "R2_R3_R11_base";
        setup(4'b0011, 1, 3, 3, 2, 20, 8, 12, 5, 9, 2);
        run(600);
        // R2: enable every other cycle
        phase = "R2_half_rate";
        en_mode = 1;
        run(700);
        // R10: mid-frame writes, some landing at the frame boundary
        phase = "R10_midframe";
        en_mode = 2;
        run(37);
        wr(4, 5); wr(1, (2 << 8) | 4);
        run(113);
        wr(6, 7); wr(12, 'h3FF); wr(15, 0);
        run(900);
        // R6 R7: hsync disabled, vsync active-high, hsync polarity set
        phase = "R6_R7_hs_off";
        en_mode = 0;
        wr(0, 4'b0110);
        run(600);
        // R5: zero hsync width acts as one, active-low syncs
        phase = "R5_R7_zero_width";
        setup(4'b0001, 0, 2, 0, 1, 16, 6, 10, 4, 0, 3);
        run(500);
        // R9: TFT mode lifts a zero line offset to 2
        phase = "R9_tft";
        wr(0, 4'b1011);
        run(500);
        // R9: STN mode again, offset 0 used as written
        phase = "R9_stn";
        wr(0, 4'b0011);
        run(400);
        // R2: totals of 0 hold counters at 0
        phase = "R2_zero_totals";
        wr(3, 0); wr(5, 0);
        run(300);
        // R1: reset mid-run returns to idle levels
        phase = "R1_rerun";
        @(negedge clk); rst_n <= 1'b0;
        run(3);
        rst_n <= 1'b1;
        run(50);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule